// File: doc/BRIEF.md
# Open-Page DRAM Bank Scheduler

This block decides, once per DRAM clock, which queued memory request goes next to an open-page DRAM with several banks. Requests come in over a valid/ready port. Each one carries an address, a write flag and a class bit that marks it as demand or prefetch. It is filed into a small per-bank queue for its class. On each scheduler tick the block looks at the queue heads and checks whether the target bank's open row matches the request's row. It then reserves the shared data bus and the bank by OR-ing case-specific masks into future-occupancy bitmaps. These bitmaps move one step closer to the present on every tick.

Issued requests wait in a completion store until a fixed latency has passed. The latency depends on read or write and on page hit or miss. Completed reads come back on one of two valid/ready response ports, one for demand and one for prefetch. Completed writes leave silently.

Back-pressure works as follows:
- `in_ready` depends only on the queue that the current `in_addr`/`in_demand` select. A source may change or withdraw its request while `in_ready` is low.
- A response stays valid, with a stable address, until its ready is seen high at a clock edge.
- A completion that is due for a port still holding an undelivered response waits. The completions behind it in wake-up order wait with it.

Top module: `dram_bank_sched`

## Requirements
- R1: Scheduling actions happen only on ticks. These actions are the bitmap shift, completion removal and issue. A tick is every TICK_DIV-th clock after reset; the first tick falls on clock TICK_DIV. On each tick the bus bitmap and every bank bitmap shift right by one before any check.
- R2: The bank of a request is `in_addr[COL_W+BANK_W-1:COL_W]`, with bank 0 at value 0. `in_demand`=1 selects the demand queue and 0 selects the prefetch queue. `in_ready` is low exactly when the selected queue holds QDEPTH entries. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. After reset every queue is empty.
- R3: The row of a request is `in_addr[ADDR_W-1:COL_W]`. A request is a page hit when its bank holds an open row equal to that row. After reset no bank has an open row. Issuing a miss makes the request's row the bank's open row.
- R4: Each access case has one bus mask and one bank mask. The four cases are read hit, read miss, write hit and write miss. A head request may issue only when neither of its masks overlaps the shifted bitmaps. Issuing ORs both masks into them.
- R5: Latency is counted in ticks: read hit 19, read miss 34, write hit 12, write miss 28. A request issued on tick number t becomes due on tick t+latency.
- R6: The first candidate on a tick is the demand head with the smallest acceptance cycle over all banks. On equal cycles the lower bank index wins.
- R7: If that candidate cannot issue, demand heads are tried round-robin, starting at the bank after the last bank used. Prefetch heads are tried in the same order only when no demand head can issue. After reset the last bank used is NB-1.
- R8: At most one request issues per tick. The issuing bank becomes the last bank used. No request issues on a tick that begins with all CQ_DEPTH completion slots occupied.
- R9: On each tick at most one due completion is removed. The one removed has the smallest wake-up tick, with the earlier issue tick breaking ties. A read goes to the demand or prefetch response port according to its class, valid from the next clock. A write produces nothing.
- R10: A response holds valid and address until accepted. A due read whose port still holds a response blocks removal on that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Selected queue has room |
| in_addr | input | ADDR_W | Request address |
| in_write | input | 1 | 1 = write, 0 = read |
| in_demand | input | 1 | 1 = demand, 0 = prefetch |
| dresp_valid | output | 1 | Demand read completion available |
| dresp_ready | input | 1 | Demand response accepted |
| dresp_addr | output | ADDR_W | Address of completed demand read |
| presp_valid | output | 1 | Prefetch read completion available |
| presp_ready | input | 1 | Prefetch response accepted |
| presp_addr | output | ADDR_W | Address of completed prefetch read |

## Verification
A corrupted open-row tag or a stray bitmap bit changes which latency a request receives or which bank wins a tick. That shows up as a response appearing on a different clock, or carrying a different address, than expected. The error is therefore visible within one completion latency, at most a few dozen ticks. A wrong queue fill count shows immediately as a wrong `in_ready` for the next request aimed at that queue. A wrong completion ordering shows as response addresses swapped between consecutive deliveries on a port.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  typedef enum logic [1:0] {
    ACC_RD_HIT  = 2'd0,
    ACC_RD_MISS = 2'd1,
    ACC_WR_HIT  = 2'd2,
    ACC_WR_MISS = 2'd3
  } acc_case_e;

  function automatic acc_case_e classify(input logic wr, input logic hit);
    if (wr) return hit ? ACC_WR_HIT : ACC_WR_MISS;
    return hit ? ACC_RD_HIT : ACC_RD_MISS;
  endfunction

endpackage

// File: rtl/dbs_fifo.sv
module dbs_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == (AW+1)'(DEPTH));
  assign dout  = mem[rp_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (pop)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  // R2: the edge interface never writes a full queue
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R8: the scheduler never takes a head from an empty queue
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/dbs_picker.sv
module dbs_picker #(
  parameter int NB     = 4,
  parameter int TS_W   = 32,
  parameter int BANK_W = $clog2(NB)
) (
  input  logic                 en,
  input  logic [NB-1:0]        d_ne,
  input  logic [NB*TS_W-1:0]   d_stamp,
  input  logic [NB-1:0]        d_ok,
  input  logic [NB-1:0]        p_ok,
  input  logic [BANK_W-1:0]    last,
  output logic                 valid,
  output logic [BANK_W-1:0]    bank,
  output logic                 kind
);
  logic              have_old;
  logic [BANK_W-1:0] old_b, idx;
  logic [TS_W-1:0]   old_st;

  always_comb begin
    have_old = 1'b0;
    old_b    = '0;
    old_st   = '0;
    idx      = '0;
    for (int b = 0; b < NB; b++) begin
      if (d_ne[b] && (!have_old || d_stamp[b*TS_W +: TS_W] < old_st)) begin
        have_old = 1'b1;
        old_b    = BANK_W'(b);
        old_st   = d_stamp[b*TS_W +: TS_W];
      end
    end
    valid = 1'b0;
    bank  = old_b;
    kind  = 1'b1;
    if (en) begin
      if (have_old && d_ok[old_b]) valid = 1'b1;
      for (int i = 1; i <= NB; i++) begin
        idx = last + BANK_W'(i);
        if (!valid && d_ok[idx]) begin
          valid = 1'b1;
          bank  = idx;
        end
      end
      for (int i = 1; i <= NB; i++) begin
        idx = last + BANK_W'(i);
        if (!valid && p_ok[idx]) begin
          valid = 1'b1;
          bank  = idx;
          kind  = 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/dbs_cmplq.sv
module dbs_cmplq #(
  parameter int ADDR_W = 16,
  parameter int TS_W   = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [TS_W-1:0]   now,
  input  logic              ins,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic              ins_wr,
  input  logic              ins_dem,
  input  logic [TS_W-1:0]   ins_wake,
  output logic              full,
  output logic              dresp_valid,
  input  logic              dresp_ready,
  output logic [ADDR_W-1:0] dresp_addr,
  output logic              presp_valid,
  input  logic              presp_ready,
  output logic [ADDR_W-1:0] presp_addr
);
  localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  v_q;
  logic [TS_W-1:0]   wake_q [DEPTH];
  logic [TS_W-1:0]   itk_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DEPTH-1:0]  wr_q, dem_q;
  logic              dv_q, pv_q;
  logic [ADDR_W-1:0] da_q, pa_q;

  logic              have, rm;
  logic [SW-1:0]     sel, fr;
  logic [2*TS_W-1:0] bkey;

  always_comb begin
    have = 1'b0;
    sel  = '0;
    bkey = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (v_q[i] && wake_q[i] <= now &&
          (!have || {wake_q[i], itk_q[i]} < bkey)) begin
        have = 1'b1;
        sel  = SW'(i);
        bkey = {wake_q[i], itk_q[i]};
      end
    end
    fr = '0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (!v_q[i]) fr = SW'(i);
    end
  end

  assign rm   = tick && have && (wr_q[sel] || (dem_q[sel] ? !dv_q : !pv_q));
  assign full = &v_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q  <= '0;
      dv_q <= 1'b0;
      pv_q <= 1'b0;
    end else begin
      if (dv_q && dresp_ready) dv_q <= 1'b0;
      if (pv_q && presp_ready) pv_q <= 1'b0;
      if (rm) begin
        v_q[sel] <= 1'b0;
        if (!wr_q[sel]) begin
          if (dem_q[sel]) dv_q <= 1'b1;
          else            pv_q <= 1'b1;
        end
      end
      if (ins) v_q[fr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins) begin
      wake_q[fr] <= ins_wake;
      itk_q[fr]  <= now;
      addr_q[fr] <= ins_addr;
      wr_q[fr]   <= ins_wr;
      dem_q[fr]  <= ins_dem;
    end
    if (rm && !wr_q[sel] &&  dem_q[sel]) da_q <= addr_q[sel];
    if (rm && !wr_q[sel] && !dem_q[sel]) pa_q <= addr_q[sel];
  end

  assign dresp_valid = dv_q;
  assign dresp_addr  = da_q;
  assign presp_valid = pv_q;
  assign presp_addr  = pa_q;

  p_dresp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dresp_valid && !dresp_ready |=> dresp_valid && $stable(dresp_addr));
  p_presp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    presp_valid && !presp_ready |=> presp_valid && $stable(presp_addr));
  p_cq_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ins |-> !full);

endmodule

// File: rtl/dram_bank_sched.sv
module dram_bank_sched #(
  parameter int          NB       = 4,
  parameter int          QDEPTH   = 4,
  parameter int          ADDR_W   = 16,
  parameter int          COL_W    = 6,
  parameter int          TICK_DIV = 2,
  parameter int          BMW      = 64,
  parameter int          CQ_DEPTH = 8,
  parameter int          TS_W     = 32,
  parameter logic [63:0] BUS_RH   = 64'h0000_0000_000F_0000,
  parameter logic [63:0] BUS_RM   = 64'h0000_0000_F000_0000,
  parameter logic [63:0] BUS_WH   = 64'h0000_0000_0000_0F00,
  parameter logic [63:0] BUS_WM   = 64'h0000_0000_00F0_0000,
  parameter logic [63:0] BANK_RH  = 64'h0000_0000_000F_FFFF,
  parameter logic [63:0] BANK_RM  = 64'h0000_0003_FFFF_FFFF,
  parameter logic [63:0] BANK_WH  = 64'h0000_0000_0000_0FFF,
  parameter logic [63:0] BANK_WM  = 64'h0000_0000_0FFF_FFFF,
  parameter int          LAT_RH   = 19,
  parameter int          LAT_RM   = 34,
  parameter int          LAT_WH   = 12,
  parameter int          LAT_WM   = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_write,
  input  logic              in_demand,
  output logic              dresp_valid,
  input  logic              dresp_ready,
  output logic [ADDR_W-1:0] dresp_addr,
  output logic              presp_valid,
  input  logic              presp_ready,
  output logic [ADDR_W-1:0] presp_addr
);
  import dbs_pkg::*;

  localparam int BANK_W = $clog2(NB);
  localparam int ROW_W  = ADDR_W - COL_W;
  localparam int DW     = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DW-1:0]     div_q;
  logic              tick, issue, cq_full, pv, pk;
  logic [BANK_W-1:0] pb, last_q, in_bank;
  logic [TS_W-1:0]   cyc_q, tk_q;
  logic [BMW-1:0]    bus_q, bus_sh;
  logic [BMW-1:0]    bank_q [NB];
  logic [BMW-1:0]    bank_sh [NB];
  logic [ROW_W-1:0]  tag_q [NB];
  logic [NB-1:0]     tag_v;

  logic              empty_v [2][NB];
  logic              full_v  [2][NB];
  logic [ADDR_W-1:0] h_addr  [2][NB];
  logic              h_wr    [2][NB];
  logic [ROW_W-1:0]  e_row   [2][NB];
  logic              e_hit   [2][NB];
  logic [BMW-1:0]    e_bus   [2][NB];
  logic [BMW-1:0]    e_bank  [2][NB];
  logic [TS_W-1:0]   e_lat   [2][NB];
  logic [NB-1:0]     d_ok, p_ok, d_ne;
  logic [NB*TS_W-1:0] d_stamp;

  assign tick     = (div_q == DW'(TICK_DIV-1));
  assign bus_sh   = bus_q >> 1;
  assign in_bank  = in_addr[COL_W +: BANK_W];
  assign in_ready = !full_v[in_demand][in_bank];

  for (genvar gb = 0; gb < NB; gb++) begin : g_bank
    assign bank_sh[gb] = bank_q[gb] >> 1;
    for (genvar gk = 0; gk < 2; gk++) begin : g_kind
      logic              push_w, pop_w, emp, ful, w, hit;
      logic [ADDR_W-1:0] a;
      logic [ROW_W-1:0]  row;
      logic [BMW-1:0]    mb, mk;
      logic [TS_W-1:0]   lat;

      assign push_w = in_valid && in_ready && (in_bank == BANK_W'(gb)) &&
                      (in_demand == 1'(gk));
      assign pop_w  = issue && (pb == BANK_W'(gb)) && (pk == 1'(gk));

      if (gk == 1) begin : g_dm
        logic [ADDR_W+TS_W:0] dout;
        dbs_fifo #(.W(ADDR_W+1+TS_W), .DEPTH(QDEPTH)) u_q (
          .clk(clk), .rst_n(rst_n), .push(push_w), .pop(pop_w),
          .din({cyc_q, in_write, in_addr}), .dout(dout),
          .empty(emp), .full(ful));
        assign a = dout[ADDR_W-1:0];
        assign w = dout[ADDR_W];
        assign d_stamp[gb*TS_W +: TS_W] = dout[ADDR_W+1 +: TS_W];
        assign d_ne[gb] = !emp;
        assign d_ok[gb] = !emp && ((mb & bus_sh) == '0) && ((mk & bank_sh[gb]) == '0);
      end else begin : g_pf
        logic [ADDR_W:0] dout;
        dbs_fifo #(.W(ADDR_W+1), .DEPTH(QDEPTH)) u_q (
          .clk(clk), .rst_n(rst_n), .push(push_w), .pop(pop_w),
          .din({in_write, in_addr}), .dout(dout),
          .empty(emp), .full(ful));
        assign a = dout[ADDR_W-1:0];
        assign w = dout[ADDR_W];
        assign p_ok[gb] = !emp && ((mb & bus_sh) == '0) && ((mk & bank_sh[gb]) == '0);
      end

      assign row = a[ADDR_W-1:COL_W];
      always_comb begin
        hit = tag_v[gb] && (tag_q[gb] == row);
        case (classify(w, hit))
          ACC_RD_HIT:  begin mb = BMW'(BUS_RH); mk = BMW'(BANK_RH); lat = TS_W'(LAT_RH); end
          ACC_RD_MISS: begin mb = BMW'(BUS_RM); mk = BMW'(BANK_RM); lat = TS_W'(LAT_RM); end
          ACC_WR_HIT:  begin mb = BMW'(BUS_WH); mk = BMW'(BANK_WH); lat = TS_W'(LAT_WH); end
          ACC_WR_MISS: begin mb = BMW'(BUS_WM); mk = BMW'(BANK_WM); lat = TS_W'(LAT_WM); end
        endcase
      end

      assign empty_v[gk][gb] = emp;
      assign full_v[gk][gb]  = ful;
      assign h_addr[gk][gb]  = a;
      assign h_wr[gk][gb]    = w;
      assign e_row[gk][gb]   = row;
      assign e_hit[gk][gb]   = hit;
      assign e_bus[gk][gb]   = mb;
      assign e_bank[gk][gb]  = mk;
      assign e_lat[gk][gb]   = lat;
    end
  end

  dbs_picker #(.NB(NB), .TS_W(TS_W), .BANK_W(BANK_W)) u_pick (
    .en(!cq_full), .d_ne(d_ne), .d_stamp(d_stamp), .d_ok(d_ok), .p_ok(p_ok),
    .last(last_q), .valid(pv), .bank(pb), .kind(pk));

  assign issue = tick && pv;

  dbs_cmplq #(.ADDR_W(ADDR_W), .TS_W(TS_W), .DEPTH(CQ_DEPTH)) u_cq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .now(tk_q),
    .ins(issue), .ins_addr(h_addr[pk][pb]), .ins_wr(h_wr[pk][pb]), .ins_dem(pk),
    .ins_wake(tk_q + e_lat[pk][pb]), .full(cq_full),
    .dresp_valid(dresp_valid), .dresp_ready(dresp_ready), .dresp_addr(dresp_addr),
    .presp_valid(presp_valid), .presp_ready(presp_ready), .presp_addr(presp_addr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      cyc_q  <= '0;
      tk_q   <= '0;
      bus_q  <= '0;
      tag_v  <= '0;
      last_q <= BANK_W'(NB-1);
      for (int b = 0; b < NB; b++) bank_q[b] <= '0;
    end else begin
      cyc_q <= cyc_q + 1'b1;
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        tk_q  <= tk_q + 1'b1;
        bus_q <= bus_sh | (issue ? e_bus[pk][pb] : '0);
        for (int b = 0; b < NB; b++)
          bank_q[b] <= bank_sh[b] | ((issue && pb == BANK_W'(b)) ? e_bank[pk][pb] : '0);
        if (issue) begin
          last_q <= pb;
          if (!e_hit[pk][pb]) tag_v[pb] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (issue && !e_hit[pk][pb]) tag_q[pb] <= e_row[pk][pb];
  end

  // R4: an issued request never collides with a reservation
  p_no_conflict_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> ((e_bus[pk][pb] & bus_sh) == '0) && ((e_bank[pk][pb] & bank_sh[pb]) == '0));
  // R7: prefetch only when no demand head can go
  p_prefetch_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !pk |-> d_ok == '0);
  // R3: after an issue the bank holds the request's row open
  p_tag_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> tag_v[$past(pb)] && tag_q[$past(pb)] == $past(e_row[pk][pb]));
  // R1: scheduling only on ticks
  p_issue_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pv && !tick |=> $stable(bus_q));
  // R2: an empty queue always has room
  p_empty_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    empty_v[in_demand][in_bank] |-> in_ready);

endmodule

// File: tb/test_dram_bank_sched.sv
module test_dram_bank_sched;
  localparam int NB = 4, QD = 4, DIV = 2, CQD = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, in_valid, in_ready, in_write, in_demand;
  logic [15:0] in_addr, dresp_addr, presp_addr;
  logic        dresp_valid, dresp_ready, presp_valid, presp_ready;

  dram_bank_sched i_dram_bank_sched (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_write(in_write), .in_demand(in_demand),
    .dresp_valid(dresp_valid), .dresp_ready(dresp_ready), .dresp_addr(dresp_addr),
    .presp_valid(presp_valid), .presp_ready(presp_ready), .presp_addr(presp_addr));

  typedef struct {logic [15:0] addr; bit wr; int unsigned stamp;} qe_t;
  typedef struct {int unsigned wake; int unsigned itk; logic [15:0] addr; bit wr; bit dem;} ce_t;

  qe_t         mq [2][NB][$];
  ce_t         cq [$];
  int          tagr [NB];
  bit          tv [NB];
  logic [63:0] mbus;
  logic [63:0] mbank [NB];
  int          last, divc;
  int unsigned tk, cycm;
  bit          dv, pv, acc_last, running, done;
  logic [15:0] da, pa;
  int          n_cmp = 0, n_bad = 0, n_reads = 0, n_resp = 0, wd = 0;

  function automatic void masks(input bit wr, input bit hit,
                                output logic [63:0] bm, output logic [63:0] km, output int lat);
    if (!wr && hit)       begin bm = 64'h0000_0000_000F_0000; km = 64'h0000_0000_000F_FFFF; lat = 19; end
    else if (!wr)         begin bm = 64'h0000_0000_F000_0000; km = 64'h0000_0003_FFFF_FFFF; lat = 34; end
    else if (hit)         begin bm = 64'h0000_0000_0000_0F00; km = 64'h0000_0000_0000_0FFF; lat = 12; end
    else                  begin bm = 64'h0000_0000_00F0_0000; km = 64'h0000_0000_0FFF_FFFF; lat = 28; end
  endfunction

  function automatic bit can_go(int k, int b);
    logic [63:0] bm, km; int lat; bit hit;
    if (mq[k][b].size() == 0) return 0;
    hit = tv[b] && (tagr[b] == int'(mq[k][b][0].addr >> 6));
    masks(mq[k][b][0].wr, hit, bm, km, lat);
    return ((bm & mbus) == 0) && ((km & mbank[b]) == 0);
  endfunction

  function automatic bit m_ready();
    return mq[in_demand][in_addr[7:6]].size() < QD;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 2; k++) for (int b = 0; b < NB; b++) mq[k][b].delete();
    cq.delete();
    for (int b = 0; b < NB; b++) begin tv[b] = 0; tagr[b] = 0; mbank[b] = '0; end
    mbus = '0; last = NB-1; divc = 0; tk = 0; cycm = 0;
    dv = 0; pv = 0; acc_last = 0;
  endtask

  task automatic model_step();
    bit acc, dv0, pv0, tick;
    acc = in_valid && m_ready();
    dv0 = dv; pv0 = pv;
    if (dv && dresp_ready) dv = 0;
    if (pv && presp_ready) pv = 0;
    tick = (divc == DIV-1);
    divc = tick ? 0 : divc + 1;
    if (tick) begin
      bit cqfull; int bi, ob, pbk, pkd; int unsigned ost;
      cqfull = (cq.size() == CQD);
      mbus = mbus >> 1;
      for (int b = 0; b < NB; b++) mbank[b] = mbank[b] >> 1;
      bi = -1;
      for (int i = 0; i < cq.size(); i++)
        if (cq[i].wake <= tk && (bi < 0 || cq[i].wake < cq[bi].wake ||
            (cq[i].wake == cq[bi].wake && cq[i].itk < cq[bi].itk))) bi = i;
      if (bi >= 0) begin
        ce_t e = cq[bi];
        if (e.wr || (e.dem ? !dv0 : !pv0)) begin
          cq.delete(bi);
          if (!e.wr) begin
            if (e.dem) begin dv = 1; da = e.addr; end
            else       begin pv = 1; pa = e.addr; end
          end
        end
      end
      pbk = -1; pkd = 1;
      if (!cqfull) begin
        ob = -1; ost = 0;
        for (int b = 0; b < NB; b++)
          if (mq[1][b].size() > 0 && (ob < 0 || mq[1][b][0].stamp < ost)) begin
            ob = b; ost = mq[1][b][0].stamp;
          end
        if (ob >= 0 && can_go(1, ob)) pbk = ob;
        for (int i = 1; i <= NB; i++)
          if (pbk < 0 && can_go(1, (last+i) % NB)) pbk = (last+i) % NB;
        if (pbk < 0) begin
          pkd = 0;
          for (int i = 1; i <= NB; i++)
            if (pbk < 0 && can_go(0, (last+i) % NB)) pbk = (last+i) % NB;
        end
      end
      if (pbk >= 0) begin
        qe_t e; logic [63:0] bm, km; int lat; bit hit;
        e = mq[pkd][pbk].pop_front();
        hit = tv[pbk] && (tagr[pbk] == int'(e.addr >> 6));
        masks(e.wr, hit, bm, km, lat);
        mbus = mbus | bm;
        mbank[pbk] = mbank[pbk] | km;
        if (!hit) begin tagr[pbk] = int'(e.addr >> 6); tv[pbk] = 1; end
        cq.push_back('{tk + lat, tk, e.addr, e.wr, pkd == 1});
        last = pbk;
      end
      tk++;
    end
    if (acc) begin
      mq[in_demand][in_addr[7:6]].push_back('{in_addr, in_write, cycm});
      if (!in_write) n_reads++;
    end
    acc_last = acc;
    cycm++;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Per-clock comparison against the reference model
  always @(negedge clk) begin
    if (rst_n && running) begin
      #2;
      check(in_ready == m_ready(), "R2", "in_ready", 32'(in_ready), 32'(m_ready()));
      check(dresp_valid == dv, "R9 R10 R1 R5", "dresp_valid", 32'(dresp_valid), 32'(dv));
      if (dv) check(dresp_addr == da, "R3 R4 R6 R7 R8 R9", "dresp_addr", 32'(dresp_addr), 32'(da));
      check(presp_valid == pv, "R9 R10 R1 R5", "presp_valid", 32'(presp_valid), 32'(pv));
      if (pv) check(presp_addr == pa, "R3 R4 R7 R8 R9", "presp_addr", 32'(presp_addr), 32'(pa));
      if (dresp_valid && dresp_ready) n_resp++;
      if (presp_valid && presp_ready) n_resp++;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", wd);
      summary();
      $finish;
    end
  end

  task automatic run_phase(input int n, input int mode);
    for (int c = 0; c < n; c++) begin
      int pval, rdy; logic [9:0] row;
      @(negedge clk);
      case (mode)
        0: begin pval = 50;  rdy = 100; end
        1: begin pval = 60;  rdy = 70;  end
        2: begin pval = 100; rdy = 0;   end
        3: begin pval = 100; rdy = 100; end
        4: begin pval = 50;  rdy = 100; end
        default: begin pval = 0; rdy = 100; end
      endcase
      if (!in_valid || acc_last) begin
        in_valid = ($urandom_range(99) < pval);
        case (mode)
          0: begin row = 10'($urandom_range(7));  in_demand = 1; in_write = ($urandom_range(3) == 0); end
          1: begin row = 10'($urandom_range(15)); in_demand = $urandom_range(1); in_write = ($urandom_range(9) < 3); end
          2, 3: begin row = 10'($urandom_range(3)); in_demand = $urandom_range(1); in_write = 0; end
          default: begin row = 10'($urandom_range(11)); in_demand = 0; in_write = 0; end
        endcase
        in_addr = {row, 6'($urandom_range(63))};
      end
      dresp_ready = ($urandom_range(99) < rdy);
      presp_ready = ($urandom_range(99) < rdy);
    end
  endtask

  initial begin
    done = 0; running = 0;
    rst_n = 0; in_valid = 0; in_addr = '0; in_write = 0; in_demand = 1;
    dresp_ready = 0; presp_ready = 0;
    repeat (3) @(negedge clk);
    #2;
    // reset state
    check(in_ready == 1'b1, "R2", "reset in_ready", 32'(in_ready), 32'd1);
    check(dresp_valid == 1'b0, "R10", "reset dresp_valid", 32'(dresp_valid), 32'd0);
    check(presp_valid == 1'b0, "R10", "reset presp_valid", 32'(presp_valid), 32'd0);
    @(negedge clk);
    rst_n = 1; running = 1;
    run_phase(3000, 0);   // demand reads/writes on few rows: hits, oldest-first
    run_phase(6000, 1);   // mixed classes with response back-pressure
    run_phase(800, 2);    // full stall: queues and completion store fill up
    run_phase(1500, 3);   // release
    run_phase(3000, 4);   // prefetch only, round-robin
    in_valid = 0;
    for (int c = 0; c < 20000; c++) begin
      bit idle;
      @(negedge clk);
      in_valid = 0; dresp_ready = 1; presp_ready = 1;
      idle = (cq.size() == 0) && !dv && !pv;
      for (int k = 0; k < 2; k++) for (int b = 0; b < NB; b++)
        if (mq[k][b].size() != 0) idle = 0;
      if (idle) break;
    end
    repeat (4) @(negedge clk);
    #3;
    check(n_resp == n_reads, "R9", "read responses delivered", 32'(n_resp), 32'(n_reads));
    check(!dresp_valid && !presp_valid, "R9", "ports idle after drain",
          32'({dresp_valid, presp_valid}), 32'd0);
    done = 1;
    summary();
    $finish;
  end

endmodule